// File: doc/BRIEF.md
# Fetch-Deadlock-Safe Request/Reply Input Stage

This block sits between a node's network input port and the local logic that serves incoming transactions. Every arriving transaction is steered by its class into one of two independent queues: a request queue that feeds the local request server and a reply queue that feeds the local reply consumer. Because the stage takes an arrival on every cycle it is offered, there is no ready signal toward the network. A full request queue turns an excess request into a negative acknowledgement back to its sender, so nothing is left waiting in the fabric.

Buffer space is reserved by class. With K outstanding requests allowed per node and P nodes, the request queue holds K*(P-1) entries and the reply queue holds K entries, so a reply can always be absorbed. If the request queue stays full while the node's outgoing response path is blocked for a programmable number of cycles, the stage treats this as a fetch deadlock. It then drains queued requests, oldest first, into an overflow store, and new arrivals are accepted again. Once the response path unblocks, the overflow contents are replayed on a loopback path to the request server ahead of every newer request. If a spill finds the overflow store full, the spilled request is NACKed instead.

Top module: `rrq_node_input`

## Requirements
- R1: A reply (`net_is_reply`=1) is never refused or NACKed. Replies reach the reply consumer in arrival order, even while the request side is full, blocked or spilling.
- R2: The request queue holds K*(P-1) = 6 entries by default. A request that arrives when 6 are held, and none leaves in that cycle, is dropped. In the next cycle `nack_valid` is 1, with `nack_dst` and `nack_data` equal to that request's source and payload.
- R3: The reply queue holds K = 2 entries. A reply that arrives at a clock edge is visible on `rpl_valid` right after that edge.
- R4: A full request queue is only declared deadlocked when `resp_blocked` has been high throughout the last `stall_limit`+1 cycles. Before that, or when `resp_blocked` is low, excess requests are NACKed.
- R5: Once the queue is deadlocked, and for as long as `resp_blocked` stays high, the head of the request queue moves into the overflow store at one entry per cycle. Requests arriving during this time are accepted.
- R6: While the overflow store is non-empty, `req_valid` is 0 whenever `resp_blocked` is 1. Otherwise the store's entries are offered first, flagged by `req_relaunched`=1, and queue entries follow only after the store is empty.
- R7: The overflow store holds 16 entries. When a spill finds it full, the request queue's head is removed and NACKed to its source.
- R8: Requests reach the request server in arrival order. Each request is delivered exactly once or NACKed exactly once.
- R9: After reset, `req_valid`, `rpl_valid` and `nack_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| net_valid | input | 1 | Arrival from the network this cycle |
| net_is_reply | input | 1 | 1 = reply class, 0 = request class |
| net_src | input | 2 | Sending node id |
| net_data | input | 16 | Transaction payload |
| stall_limit | input | 8 | Blocked cycles tolerated before a deadlock is declared |
| resp_blocked | input | 1 | The node's outgoing response path cannot accept traffic |
| req_valid | output | 1 | Request offered to the local request server |
| req_ready | input | 1 | Request server takes the offered request |
| req_src | output | 2 | Source of the offered request |
| req_data | output | 16 | Payload of the offered request |
| req_relaunched | output | 1 | Offered request comes from the overflow store |
| rpl_valid | output | 1 | Reply offered to the reply consumer |
| rpl_ready | input | 1 | Reply consumer takes the offered reply |
| rpl_src | output | 2 | Source of the offered reply |
| rpl_data | output | 16 | Payload of the offered reply |
| nack_valid | output | 1 | A refused request is being bounced |
| nack_dst | output | 2 | Node the NACK returns to |
| nack_data | output | 16 | Payload of the refused request |

## Verification
The hardest state to reach is the fallback inside the spill, where the overflow store is already full and yet more requests are waiting to spill. The bench gets there directly: it holds the response path blocked, sets a zero stall limit, and sends two dozen requests back to back. The store fills, and the remaining heads are NACKed. After the response path unblocks, the bench counts that exactly 16 relaunched requests come out and that every request is accounted for exactly once. Random traffic with a toggling blocked signal then mixes spills, relaunches and replies.

// File: rtl/rrq_pkg.sv
package rrq_pkg;

    localparam int K_OUT_DEF     = 2;
    localparam int N_NODES_DEF   = 4;
    localparam int OVF_SLOTS_DEF = 16;
    localparam int PAYLOAD_W_DEF = 16;
    localparam int LIMIT_W_DEF   = 8;

    // Request slots needed so that every peer can have K requests in flight.
    function automatic int req_slots(input int k_out, input int n_nodes);
        return k_out * (n_nodes - 1);
    endfunction

    // Which store feeds the request server this cycle.
    typedef enum logic [1:0] {
        PICK_NONE  = 2'd0,
        PICK_OVF   = 2'd1,
        PICK_QUEUE = 2'd2
    } req_pick_e;

endpackage

// File: rtl/rrq_fifo.sv
module rrq_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              push,
    input  logic [WIDTH-1:0]                  push_data,
    input  logic                              pop,
    output logic [WIDTH-1:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]        count,
    output logic                              full,
    output logic                              empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2 / R7: callers never write into a full store unless a slot frees in the same cycle
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));

    // R8: nothing is taken from an empty store
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/rrq_stall_mon.sv
module rrq_stall_mon #(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_full,
    input  logic               resp_blocked,
    input  logic [LIMIT_W-1:0] stall_limit,
    output logic               spill_active
);
    logic [LIMIT_W:0] stall_cnt;
    logic             stalled;
    logic             deadlock_now;

    assign stalled      = req_full && resp_blocked;
    assign deadlock_now = stalled && (stall_cnt >= {1'b0, stall_limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_cnt    <= '0;
            spill_active <= 1'b0;
        end else begin
            if (!stalled) begin
                stall_cnt <= '0;
            end else if (!stall_cnt[LIMIT_W]) begin
                stall_cnt <= stall_cnt + 1'b1;
            end
            spill_active <= resp_blocked && (spill_active || deadlock_now);
        end
    end

    // R4: spilling only follows a cycle in which the response path was blocked
    assert_spill_needs_block_R4: assert property (@(posedge clk) disable iff (rst)
        spill_active |-> $past(resp_blocked));

    // R4: a spill never starts without a full request queue
    assert_spill_needs_full_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(spill_active) |-> $past(req_full));

endmodule

// File: rtl/rrq_steer.sv
module rrq_steer (
    input  logic net_valid,
    input  logic net_is_reply,
    input  logic req_full,
    input  logic req_pop,
    output logic push_req,
    output logic push_rpl,
    output logic nack_arrival
);
    logic req_room;

    assign req_room     = !req_full || req_pop;
    assign push_rpl     = net_valid && net_is_reply;
    assign push_req     = net_valid && !net_is_reply && req_room;
    assign nack_arrival = net_valid && !net_is_reply && !req_room;

    // R1: a reply is never bounced
    always_comb begin
        assert_reply_not_bounced_R1: assert (!(push_rpl && nack_arrival));
    end

endmodule

// File: rtl/rrq_node_input.sv
module rrq_node_input #(
    parameter int K_OUT     = rrq_pkg::K_OUT_DEF,
    parameter int N_NODES   = rrq_pkg::N_NODES_DEF,
    parameter int OVF_SLOTS = rrq_pkg::OVF_SLOTS_DEF,
    parameter int PAYLOAD_W = rrq_pkg::PAYLOAD_W_DEF,
    parameter int LIMIT_W   = rrq_pkg::LIMIT_W_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         net_valid,
    input  logic                         net_is_reply,
    input  logic [$clog2(N_NODES)-1:0]   net_src,
    input  logic [PAYLOAD_W-1:0]         net_data,
    input  logic [LIMIT_W-1:0]           stall_limit,
    input  logic                         resp_blocked,
    output logic                         req_valid,
    input  logic                         req_ready,
    output logic [$clog2(N_NODES)-1:0]   req_src,
    output logic [PAYLOAD_W-1:0]         req_data,
    output logic                         req_relaunched,
    output logic                         rpl_valid,
    input  logic                         rpl_ready,
    output logic [$clog2(N_NODES)-1:0]   rpl_src,
    output logic [PAYLOAD_W-1:0]         rpl_data,
    output logic                         nack_valid,
    output logic [$clog2(N_NODES)-1:0]   nack_dst,
    output logic [PAYLOAD_W-1:0]         nack_data
);
    import rrq_pkg::*;

    localparam int NODE_W    = $clog2(N_NODES);
    localparam int REQ_DEPTH = req_slots(K_OUT, N_NODES);
    localparam int RPL_DEPTH = K_OUT;
    localparam int XW        = NODE_W + PAYLOAD_W;

    typedef struct packed {
        logic [NODE_W-1:0]    src;
        logic [PAYLOAD_W-1:0] payload;
    } xact_t;

    xact_t arrival;
    assign arrival = '{src: net_src, payload: net_data};

    // Request queue
    xact_t q_head;
    logic  q_push, q_pop, q_full, q_empty;
    logic [$clog2(REQ_DEPTH+1)-1:0] q_count;

    // Reply queue
    xact_t r_head;
    logic  r_push, r_pop, r_full, r_empty;
    logic [$clog2(RPL_DEPTH+1)-1:0] r_count;

    // Overflow store
    xact_t o_head;
    logic  o_push, o_pop, o_full, o_empty;
    logic [$clog2(OVF_SLOTS+1)-1:0] o_count;

    logic      spill_active, spill_go, spill_nack, nack_arrival, take;
    req_pick_e pick;

    rrq_fifo #(.WIDTH(XW), .DEPTH(REQ_DEPTH)) u_req_q (
        .clk(clk), .rst(rst), .push(q_push), .push_data(arrival), .pop(q_pop),
        .head(q_head), .count(q_count), .full(q_full), .empty(q_empty)
    );

    rrq_fifo #(.WIDTH(XW), .DEPTH(RPL_DEPTH)) u_rpl_q (
        .clk(clk), .rst(rst), .push(r_push), .push_data(arrival), .pop(r_pop),
        .head(r_head), .count(r_count), .full(r_full), .empty(r_empty)
    );

    rrq_fifo #(.WIDTH(XW), .DEPTH(OVF_SLOTS)) u_ovf (
        .clk(clk), .rst(rst), .push(o_push), .push_data(q_head), .pop(o_pop),
        .head(o_head), .count(o_count), .full(o_full), .empty(o_empty)
    );

    rrq_stall_mon #(.LIMIT_W(LIMIT_W)) u_stall (
        .clk(clk), .rst(rst), .req_full(q_full), .resp_blocked(resp_blocked),
        .stall_limit(stall_limit), .spill_active(spill_active)
    );

    rrq_steer u_steer (
        .net_valid(net_valid), .net_is_reply(net_is_reply), .req_full(q_full),
        .req_pop(q_pop), .push_req(q_push), .push_rpl(r_push),
        .nack_arrival(nack_arrival)
    );

    // Request server feed: overflow first, then the live queue.
    always_comb begin
        if (!o_empty) begin
            pick = resp_blocked ? PICK_NONE : PICK_OVF;
        end else if (!q_empty && !spill_active) begin
            pick = PICK_QUEUE;
        end else begin
            pick = PICK_NONE;
        end
    end

    assign req_valid      = (pick != PICK_NONE);
    assign req_relaunched = (pick == PICK_OVF);
    assign req_src        = (pick == PICK_OVF) ? o_head.src     : q_head.src;
    assign req_data       = (pick == PICK_OVF) ? o_head.payload : q_head.payload;
    assign take           = req_valid && req_ready;

    // Spill path: queue head goes to the overflow store, or is bounced when it is full.
    assign spill_go   = spill_active && resp_blocked && !q_empty;
    assign o_push     = spill_go && !o_full;
    assign spill_nack = spill_go && o_full;
    assign o_pop      = take && (pick == PICK_OVF);
    assign q_pop      = spill_go || (take && (pick == PICK_QUEUE));

    // Reply side
    assign rpl_valid = !r_empty;
    assign rpl_src   = r_head.src;
    assign rpl_data  = r_head.payload;
    assign r_pop     = rpl_valid && rpl_ready;

    // Registered NACK output
    always_ff @(posedge clk) begin
        if (rst) begin
            nack_valid <= 1'b0;
            nack_dst   <= '0;
            nack_data  <= '0;
        end else begin
            nack_valid <= nack_arrival || spill_nack;
            if (nack_arrival) begin
                nack_dst  <= net_src;
                nack_data <= net_data;
            end else if (spill_nack) begin
                nack_dst  <= q_head.src;
                nack_data <= q_head.payload;
            end
        end
    end

    // R1: reserved reply space is never exceeded
    assert_reply_room_R1: assert property (@(posedge clk) disable iff (rst)
        r_push |-> (!r_full || r_pop));

    // R3: an arriving reply is offered right after the edge
    assert_reply_visible_R3: assert property (@(posedge clk) disable iff (rst)
        (net_valid && net_is_reply) |=> rpl_valid);

    // R2: a refused request bounces to its sender one cycle later
    assert_nack_to_sender_R2: assert property (@(posedge clk) disable iff (rst)
        nack_arrival |=> (nack_valid && nack_dst == $past(net_src)
                          && nack_data == $past(net_data)));

    // R6: queue entries are never offered while relaunch entries wait
    assert_relaunch_first_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_relaunched) |-> o_empty);

    // R6: nothing is relaunched while the response path is blocked
    assert_relaunch_waits_R6: assert property (@(posedge clk) disable iff (rst)
        (!o_empty && resp_blocked) |-> !req_valid);

    // R7: a spill into a full overflow store produces a NACK next cycle
    assert_spill_fallback_R7: assert property (@(posedge clk) disable iff (rst)
        (spill_active && resp_blocked && !q_empty && o_full) |=> nack_valid);

    // R7: the two NACK sources never collide
    assert_single_nack_R7: assert property (@(posedge clk) disable iff (rst)
        !(nack_arrival && spill_nack));

endmodule

// File: tb/test_rrq_node_input.sv
module test_rrq_node_input;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        net_valid = 1'b0, net_is_reply = 1'b0;
    logic [1:0]  net_src = '0;
    logic [15:0] net_data = '0;
    logic [7:0]  stall_limit = 8'd4;
    logic        resp_blocked = 1'b0;
    logic        req_valid, req_ready = 1'b0, req_relaunched;
    logic [1:0]  req_src, rpl_src, nack_dst;
    logic [15:0] req_data, rpl_data, nack_data;
    logic        rpl_valid, rpl_ready = 1'b0, nack_valid;

    int tests = 0, fails = 0;
    int req_seq = 0, rpl_seq = 0;
    int sent_req = 0, deliv_req = 0, nack_cnt = 0, relaunch_cnt = 0;
    int rpl_sent = 0, rpl_deliv = 0;
    int last_req = -1;
    logic [1:0]  last_nack_dst = '0;
    logic [15:0] last_nack_data = '0;
    bit done = 0;

    always #5 clk = ~clk;

    rrq_node_input i_rrq_node_input (
        .clk(clk), .rst(rst), .net_valid(net_valid), .net_is_reply(net_is_reply),
        .net_src(net_src), .net_data(net_data), .stall_limit(stall_limit),
        .resp_blocked(resp_blocked), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_data(req_data), .req_relaunched(req_relaunched),
        .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_src(rpl_src),
        .rpl_data(rpl_data), .nack_valid(nack_valid), .nack_dst(nack_dst),
        .nack_data(nack_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] req_word(input int s);
        return {1'b0, 15'(s)};
    endfunction

    function automatic logic [15:0] rpl_word(input int s);
        return {1'b1, 15'(s)};
    endfunction

    // Monitor: samples away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (req_valid && req_ready) begin
                check(int'(req_data[14:0]) > last_req && !req_data[15], "R8 order",
                      int'(req_data[14:0]), last_req + 1);
                last_req = int'(req_data[14:0]);
                deliv_req++;
                if (req_relaunched) relaunch_cnt++;
            end
            if (rpl_valid && rpl_ready) begin
                check(rpl_data == rpl_word(rpl_deliv), "R1 reply order",
                      int'(rpl_data), int'(rpl_word(rpl_deliv)));
                rpl_deliv++;
            end
            if (nack_valid) begin
                check(!nack_data[15], "R1 reply never nacked", int'(nack_data[15]), 0);
                nack_cnt++;
                last_nack_dst  = nack_dst;
                last_nack_data = nack_data;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic put_req(input logic [1:0] src);
        net_valid = 1'b1; net_is_reply = 1'b0; net_src = src;
        net_data = req_word(req_seq);
        req_seq++; sent_req++;
        step();
        net_valid = 1'b0;
    endtask

    task automatic put_rpl(input logic [1:0] src);
        net_valid = 1'b1; net_is_reply = 1'b1; net_src = src;
        net_data = rpl_word(rpl_seq);
        rpl_seq++; rpl_sent++;
        step();
        net_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        resp_blocked = 1'b0; req_ready = 1'b1; rpl_ready = 1'b1;
        repeat (60) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n0, d0, r0;
        logic [15:0] exp_word;
        void'($urandom(32'd2024));

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!req_valid, "R9 req_valid", int'(req_valid), 0);
        check(!rpl_valid, "R9 rpl_valid", int'(rpl_valid), 0);
        check(!nack_valid, "R9 nack_valid", int'(nack_valid), 0);
        rst = 1'b0;
        step();

        // R3: two replies held, visible right after arrival
        rpl_ready = 1'b0;
        put_rpl(2'd1);
        settle();
        check(rpl_valid, "R3 reply visible", int'(rpl_valid), 1);
        check(rpl_src == 2'd1, "R3 reply src", int'(rpl_src), 1);
        step();
        put_rpl(2'd2);
        drain();
        check(rpl_deliv == 2, "R3 two replies held", rpl_deliv, 2);

        // R2: queue depth 6, seventh request bounced to its sender
        @(negedge clk);
        resp_blocked = 1'b0; req_ready = 1'b0; stall_limit = 8'd3;
        step();
        n0 = nack_cnt;
        for (int i = 0; i < 6; i++) put_req(2'(i));
        settle();
        check(nack_cnt == n0, "R2 six accepted", nack_cnt - n0, 0);
        check(req_valid && !req_relaunched, "R2 head offered", int'(req_valid), 1);
        step();
        exp_word = req_word(req_seq);
        put_req(2'd3);
        settle();
        check(nack_cnt == n0 + 1, "R2 seventh nacked", nack_cnt - n0, 1);
        check(last_nack_dst == 2'd3, "R2 nack dst", int'(last_nack_dst), 3);
        check(last_nack_data == exp_word, "R2 nack data", int'(last_nack_data), int'(exp_word));
        // R4: no spill while the response path flows
        repeat (20) step();
        put_req(2'd2);
        settle();
        check(nack_cnt == n0 + 2, "R4 unblocked full still nacks", nack_cnt - n0, 2);
        step();
        drain();

        // R4 / R5 / R6: stall limit, spill, relaunch
        @(negedge clk);
        resp_blocked = 1'b1; req_ready = 1'b0; rpl_ready = 1'b0; stall_limit = 8'd5;
        step();
        n0 = nack_cnt; r0 = relaunch_cnt;
        for (int i = 0; i < 6; i++) put_req(2'd1);
        step(); step();
        put_req(2'd0);
        settle();
        check(nack_cnt == n0 + 1, "R4 nack before limit", nack_cnt - n0, 1);
        step();
        repeat (20) step();
        put_req(2'd2);
        settle();
        check(nack_cnt == n0 + 1, "R5 accepted while spilling", nack_cnt - n0, 1);
        check(!req_valid, "R6 no relaunch while blocked", int'(req_valid), 0);
        step();
        // R1: reply accepted while requests are spilled and blocked
        put_rpl(2'd3);
        settle();
        check(rpl_valid, "R1 reply during spill", int'(rpl_valid), 1);
        step();
        resp_blocked = 1'b0; req_ready = 1'b1; rpl_ready = 1'b1;
        step();
        put_req(2'd1);           // newer request must follow the relaunched ones
        repeat (40) step();
        check(relaunch_cnt - r0 == 7, "R6 relaunched count", relaunch_cnt - r0, 7);
        check(sent_req == deliv_req + nack_cnt, "R8 conservation", deliv_req + nack_cnt, sent_req);

        // R7: overflow store fills, further spills fall back to NACK
        @(negedge clk);
        resp_blocked = 1'b1; req_ready = 1'b0; stall_limit = 8'd0;
        step();
        n0 = nack_cnt; r0 = relaunch_cnt; d0 = deliv_req;
        for (int i = 0; i < 24; i++) put_req(2'(i));
        repeat (10) step();
        settle();
        check(nack_cnt - n0 > 1, "R7 fallback nacks", nack_cnt - n0, 8);
        step();
        drain();
        check(relaunch_cnt - r0 == 16, "R7 store of 16", relaunch_cnt - r0, 16);
        check((deliv_req - d0) + (nack_cnt - n0) == 24, "R8 each once",
              (deliv_req - d0) + (nack_cnt - n0), 24);

        // Random mix with a toggling response path
        @(negedge clk);
        stall_limit = 8'd4; resp_blocked = 1'b0;
        step();
        for (int i = 0; i < 3000; i++) begin
            int r;
            if ($urandom % 20 == 0) resp_blocked = !resp_blocked;
            req_ready = !resp_blocked && ($urandom % 4 != 0);
            rpl_ready = ($urandom % 3 != 0);
            r = $urandom % 10;
            if (r < 3 && (rpl_sent - rpl_deliv) < 2) begin
                net_valid = 1'b1; net_is_reply = 1'b1; net_src = 2'($urandom);
                net_data = rpl_word(rpl_seq); rpl_seq++; rpl_sent++;
            end else if (r < 7) begin
                net_valid = 1'b1; net_is_reply = 1'b0; net_src = 2'($urandom);
                net_data = req_word(req_seq); req_seq++; sent_req++;
            end else begin
                net_valid = 1'b0;
            end
            step();
        end
        net_valid = 1'b0;
        drain();
        check(sent_req == deliv_req + nack_cnt, "R8 final conservation",
              deliv_req + nack_cnt, sent_req);
        check(rpl_sent == rpl_deliv, "R1 all replies delivered", rpl_deliv, rpl_sent);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule